// File: doc/BRIEF.md
# Conditional Branch Resolver

This unit decides conditional branches for a processor execute stage. Each issued branch supplies a 4-bit condition code, the destination operand, the carry flag, the source operand, an immediate flag, an extension-prefix flag, the current program counter and the execution mode. One cycle later the unit reports whether the branch is taken, the resolved 20-bit target, and, for the counting forms, the incremented or decremented destination value to be written back.

There are two kinds of condition. Test-only conditions compare the destination with zero or all ones, look at its top bit, or detect signed overflow: the top bit differs from carry. Counting conditions first decrement or increment the destination and then test the result.

The target comes from the source operand. When the immediate flag is clear, the source holds an absolute address. When it is set, the source holds a signed offset in whole instructions. That offset is 9 bits, or 20 bits when an extension prefix came before it. It is applied from the address of the next instruction. In the byte-addressed mode it is scaled by four.

Top module: `branch_eval_unit`

## Requirements
- R1: With `imm` low, `target` equals `sval[19:0]`, whatever the upper source bits and `aug` are.
- R2: With `imm` high and `aug` low, the offset is `sval[8:0]` read as a signed value (-256..+255); upper source bits are ignored.
- R3: With `imm` high and `aug` high, the offset is `sval[19:0]` read as a signed value (-524288..+524287).
- R4: When `hub_mode` is low, the relative target is `pc + 1 + offset`. When `hub_mode` is high, it is `pc + 4 + 4*offset`. All target arithmetic wraps modulo 2^20.
- R5: Test codes on `op` set `taken` as follows: 0 when D is zero, 1 when D is nonzero, 2 when D is all ones, 3 when D is not all ones, 4 when D[31] is 1, 5 when D[31] is 0, and 6 when D[31] differs from `cflag`.
- R6: Decrement codes write back D-1 and set `taken` on that result as follows: 8 when it is zero, 9 when it is nonzero, 10 when it is all ones, and 11 when it is not all ones.
- R7: Increment codes write back D+1 and set `taken` on that result as follows: 12 when it is zero, and 13 when it is nonzero.
- R8: `wb_en` is high for codes 8..13 whether or not the branch is taken. For every other code, `wb_en` is low and `wb_data` is zero.
- R9: Codes 7, 14 and 15 are never taken and never write back.
- R10: Results appear, with `out_valid` high, on the clock edge after the one that samples `in_valid` high. While `out_valid` is low, `taken` and `wb_en` are low. After reset, `out_valid`, `taken` and `wb_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A branch is issued this cycle |
| op | input | 4 | Condition code |
| dval | input | 32 | Destination operand |
| cflag | input | 1 | Carry flag |
| sval | input | 32 | Source operand (address or offset) |
| imm | input | 1 | Source is an immediate offset |
| aug | input | 1 | Extension prefix widens the offset to 20 bits |
| pc | input | 20 | Address of the branch instruction |
| hub_mode | input | 1 | Byte-addressed mode (offsets scaled by 4) |
| out_valid | output | 1 | Results valid |
| taken | output | 1 | Branch taken |
| target | output | 20 | Resolved branch target |
| wb_en | output | 1 | Destination write-back enable |
| wb_data | output | 32 | Value to write back |

## Verification
The assertions check several behaviours on every cycle. They check the absolute-target path and the zero test against the sampled inputs. They check that decrement write-back equals the prior operand minus one. They check that test-only codes never enable write-back, and that an idle output carries no decision. Other behaviours can only be shown by the bench's scenarios, which compare against hand-computed expected values. These are the signed edges of both offset widths, scaling in byte-addressed mode, and target wrap past the top of the 20-bit space. They also include borrow on zero, increment through all ones to zero, the overflow test for both carry values, and the reserved codes.

// File: rtl/branch_eval_unit.sv
module branch_eval_unit #(
  parameter int DW  = 32,
  parameter int AW  = 20,
  parameter int SW  = 9,
  parameter int OPW = 4,
  parameter int HUB_SHIFT = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  dval,
  input  logic           cflag,
  input  logic [DW-1:0]  sval,
  input  logic           imm,
  input  logic           aug,
  input  logic [AW-1:0]  pc,
  input  logic           hub_mode,
  output logic           out_valid,
  output logic           taken,
  output logic [AW-1:0]  target,
  output logic           wb_en,
  output logic [DW-1:0]  wb_data
);

  localparam logic [AW-1:0] STEP_LOCAL = AW'(1);
  localparam logic [AW-1:0] STEP_HUB   = AW'(1) << HUB_SHIFT;
  localparam logic [DW-1:0] ALL_ONES   = '1;

  logic [AW-1:0] off_short, off_sel, off_scaled, next_pc, tgt_n;
  logic [DW-1:0] dec_v, inc_v, res_n;
  logic          taken_n, wb_n;

  assign off_short  = {{(AW-SW){sval[SW-1]}}, sval[SW-1:0]};
  assign off_sel    = aug ? sval[AW-1:0] : off_short;
  assign off_scaled = hub_mode ? (off_sel << HUB_SHIFT) : off_sel;
  assign next_pc    = pc + (hub_mode ? STEP_HUB : STEP_LOCAL);
  assign tgt_n      = imm ? (next_pc + off_scaled) : sval[AW-1:0];
  assign dec_v      = dval - DW'(1);
  assign inc_v      = dval + DW'(1);

  always_comb begin
    taken_n = 1'b0;
    wb_n    = 1'b0;
    res_n   = '0;
    case (op)
      4'd0:  taken_n = (dval == '0);
      4'd1:  taken_n = (dval != '0);
      4'd2:  taken_n = (dval == ALL_ONES);
      4'd3:  taken_n = (dval != ALL_ONES);
      4'd4:  taken_n = dval[DW-1];
      4'd5:  taken_n = !dval[DW-1];
      4'd6:  taken_n = dval[DW-1] != cflag;
      4'd8:  begin wb_n = 1'b1; res_n = dec_v; taken_n = (dec_v == '0);      end
      4'd9:  begin wb_n = 1'b1; res_n = dec_v; taken_n = (dec_v != '0);      end
      4'd10: begin wb_n = 1'b1; res_n = dec_v; taken_n = (dec_v == ALL_ONES); end
      4'd11: begin wb_n = 1'b1; res_n = dec_v; taken_n = (dec_v != ALL_ONES); end
      4'd12: begin wb_n = 1'b1; res_n = inc_v; taken_n = (inc_v == '0);      end
      4'd13: begin wb_n = 1'b1; res_n = inc_v; taken_n = (inc_v != '0);      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
      target    <= '0;
      wb_en     <= 1'b0;
      wb_data   <= '0;
    end else begin
      out_valid <= in_valid;
      taken     <= in_valid && taken_n;
      wb_en     <= in_valid && wb_n;
      if (in_valid) begin
        target  <= tgt_n;
        wb_data <= res_n;
      end
    end
  end

  // R1: absolute target passes the low source bits through
  a_r1_abs_target: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !imm |=> target == $past(sval[AW-1:0]));

  // R5: zero test
  a_r5_zero_test: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == 4'd0 |=> taken == ($past(dval) == '0));

  // R6: decrement write-back value
  a_r6_dec_wb: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op[3:2] == 2'b10 |=> wb_en && wb_data == $past(dval) - DW'(1));

  // R8: test-only codes never write back
  a_r8_no_wb_test: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !op[3] |=> !wb_en);

  // R10: idle output carries no decision
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !taken && !wb_en);

  // R10: one-cycle latency
  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

endmodule

// File: tb/branch_eval_unit_tb.sv
module branch_eval_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  op;
  logic [31:0] dval;
  logic        cflag;
  logic [31:0] sval;
  logic        imm, aug;
  logic [19:0] pc;
  logic        hub_mode;
  logic        out_valid, taken, wb_en;
  logic [19:0] target;
  logic [31:0] wb_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  branch_eval_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .dval(dval),
    .cflag(cflag), .sval(sval), .imm(imm), .aug(aug), .pc(pc),
    .hub_mode(hub_mode), .out_valid(out_valid), .taken(taken),
    .target(target), .wb_en(wb_en), .wb_data(wb_data)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] d;
    logic        c;
    logic [31:0] s;
    logic        im;
    logic        au;
    logic [19:0] p;
    logic        hub;
    logic        e_tk;
    logic [19:0] e_tg;
    logic        e_we;
    logic [31:0] e_wd;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VT [NV] = '{
    // R1 R5: zero test, absolute target with junk upper bits
    '{4'd0,  32'h0,        1'b0, 32'hFFF12345, 1'b0, 1'b0, 20'h00100, 1'b0, 1'b1, 20'h12345, 1'b0, 32'h0},
    // R2 R5: nonzero not taken, short offset +16, upper bits ignored
    '{4'd1,  32'h0,        1'b0, 32'hABC00010, 1'b1, 1'b0, 20'h00100, 1'b0, 1'b0, 20'h00111, 1'b0, 32'h0},
    // R2 R5: all ones, offset -1
    '{4'd2,  32'hFFFFFFFF, 1'b0, 32'h000001FF, 1'b1, 1'b0, 20'h00100, 1'b0, 1'b1, 20'h00100, 1'b0, 32'h0},
    // R2 R4 R5: not all ones, offset -256 wraps below zero
    '{4'd3,  32'hFFFFFFFE, 1'b0, 32'h00000100, 1'b1, 1'b0, 20'h00050, 1'b0, 1'b1, 20'hFFF51, 1'b0, 32'h0},
    // R4 R5: sign set, byte mode scaling
    '{4'd4,  32'h80000000, 1'b0, 32'h00000004, 1'b1, 1'b0, 20'h01000, 1'b1, 1'b1, 20'h01014, 1'b0, 32'h0},
    // R1 R5: sign clear not taken
    '{4'd5,  32'h80000000, 1'b0, 32'h000ABCDE, 1'b0, 1'b0, 20'h00000, 1'b0, 1'b0, 20'hABCDE, 1'b0, 32'h0},
    // R3 R5: overflow with C=0, max positive long offset
    '{4'd6,  32'h80000000, 1'b0, 32'h0007FFFF, 1'b1, 1'b1, 20'h00000, 1'b0, 1'b1, 20'h80000, 1'b0, 32'h0},
    // R3 R5: no overflow with C=1, most negative long offset
    '{4'd6,  32'h80000000, 1'b1, 32'h00080000, 1'b1, 1'b1, 20'h80000, 1'b0, 1'b0, 20'h00001, 1'b0, 32'h0},
    // R6: decrement to zero taken
    '{4'd8,  32'h00000001, 1'b0, 32'h00000002, 1'b1, 1'b0, 20'h00010, 1'b0, 1'b1, 20'h00013, 1'b1, 32'h0},
    // R6 R8: decrement nonzero not taken, still writes back
    '{4'd9,  32'h00000001, 1'b0, 32'h00000002, 1'b1, 1'b0, 20'h00010, 1'b0, 1'b0, 20'h00013, 1'b1, 32'h0},
    // R6: borrow from zero
    '{4'd10, 32'h00000000, 1'b0, 32'h00000200, 1'b0, 1'b0, 20'h00000, 1'b0, 1'b1, 20'h00200, 1'b1, 32'hFFFFFFFF},
    // R3 R4 R6: no borrow, long -1 in byte mode
    '{4'd11, 32'h00000005, 1'b0, 32'h000FFFFF, 1'b1, 1'b1, 20'h02000, 1'b1, 1'b1, 20'h02000, 1'b1, 32'h00000004},
    // R4 R7: increment to zero, byte-mode wrap of next address
    '{4'd12, 32'hFFFFFFFF, 1'b0, 32'h000000FF, 1'b1, 1'b0, 20'hFFFFC, 1'b1, 1'b1, 20'h003FC, 1'b1, 32'h0},
    // R4 R7: increment nonzero not taken, local wrap
    '{4'd13, 32'hFFFFFFFF, 1'b0, 32'h00000000, 1'b1, 1'b0, 20'hFFFFF, 1'b0, 1'b0, 20'h00000, 1'b1, 32'h0},
    // R9: reserved code
    '{4'd7,  32'h00000000, 1'b1, 32'h00000000, 1'b1, 1'b0, 20'h00000, 1'b0, 1'b0, 20'h00001, 1'b0, 32'h0},
    // R1: prefix flag has no effect on an absolute target
    '{4'd0,  32'h00000005, 1'b0, 32'h00012345, 1'b0, 1'b1, 20'h00400, 1'b1, 1'b0, 20'h12345, 1'b0, 32'h0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] o, input logic [31:0] d, input logic c,
                       input logic [31:0] s, input logic i, input logic a,
                       input logic [19:0] p, input logic h);
    in_valid = 1'b1; op = o; dval = d; cflag = c; sval = s;
    imm = i; aug = a; pc = p; hub_mode = h;
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op = '0; dval = '0; cflag = 1'b0;
    sval = '0; imm = 1'b0; aug = 1'b0; pc = '0; hub_mode = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 reset out_valid", {31'b0, out_valid}, 32'd0);
    chk("R10 reset taken", {31'b0, taken}, 32'd0);
    chk("R10 reset wb_en", {31'b0, wb_en}, 32'd0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      issue(VT[k].op, VT[k].d, VT[k].c, VT[k].s, VT[k].im, VT[k].au, VT[k].p, VT[k].hub);
      @(negedge clk);
      in_valid = 1'b0;
      chk($sformatf("R10 vec%0d valid", k), {31'b0, out_valid}, 32'd1);
      chk($sformatf("R5-7 vec%0d taken", k), {31'b0, taken}, {31'b0, VT[k].e_tk});
      chk($sformatf("R1-4 vec%0d target", k), {12'b0, target}, {12'b0, VT[k].e_tg});
      chk($sformatf("R8 vec%0d wb_en", k), {31'b0, wb_en}, {31'b0, VT[k].e_we});
      chk($sformatf("R8 vec%0d wb_data", k), wb_data, VT[k].e_wd);
    end

    // R10: idle cycle after a taken branch clears decision
    @(negedge clk);
    issue(4'd8, 32'h1, 1'b0, 32'h0, 1'b0, 1'b0, 20'h0, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 taken before idle", {31'b0, taken}, 32'd1);
    @(negedge clk);
    chk("R10 idle out_valid", {31'b0, out_valid}, 32'd0);
    chk("R10 idle taken", {31'b0, taken}, 32'd0);
    chk("R10 idle wb_en", {31'b0, wb_en}, 32'd0);

    // R9: codes 14 and 15 never taken, never write back
    for (int o = 14; o < 16; o++) begin
      @(negedge clk);
      issue(4'(o), 32'h0, 1'b1, 32'h0, 1'b0, 1'b0, 20'h0, 1'b0);
      @(negedge clk);
      in_valid = 1'b0;
      chk($sformatf("R9 code%0d taken", o), {31'b0, taken}, 32'd0);
      chk($sformatf("R9 code%0d wb_en", o), {31'b0, wb_en}, 32'd0);
    end

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog expired actual=hung expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule